// File: doc/BRIEF.md
# Rotating-Priority Vectored Interrupt Arbiter

This block chooses which of sixteen interrupt sources the processor services next and tells it where to go. Pending requests arrive on a 16-bit input from separate capture logic. The arbiter combines them with a mask, an in-service register and a one-hot first-priority pointer. From these it drives a single registered interrupt request. The processor answers with a read strobe. A status bit chooses between an acknowledge cycle, which enters a new handler, and a return cycle, which leaves the current one. Each cycle yields an 8-bit vector and updates the in-service and priority state. An acknowledge also pulses a one-hot pending-clear output back to the capture logic.

Priority is a circular scan. It starts at the source marked by the first-priority pointer and moves upward, wrapping from 15 back to 0. The arbiter has two modes. Fixed mode allows nested handlers, and it also allows cascade sources, which are downstream controllers that may re-enter at their own priority level; a per-source nesting count tracks each cascade source. Auto-rotate mode serves one handler at a time and moves the pointer after each acknowledge and each return.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, the mask is all ones, the in-service register is zero, the first-priority pointer is 0x0001, the mode is auto-rotate, the vector base is 0 and the interrupt output is low. A mask bit of 1 disables its source.
- R2: A pending source whose mask bit is 1 never raises the interrupt output and is never chosen by an acknowledge.
- R3: A write with regSel=3 loads the pointer with a one-hot value at the index given in regWrData[3:0]. The scan starts at that bit and wraps upward through all 16 positions. Other register selects are: 0 mask, 1 in-service, 2 cascade-select, 4 vector base (regWrData[7:4]) and 5 mode (regWrData[0], 1 = fixed). Selects 6 and 7 change nothing.
- R4: In fixed mode, the interrupt output is high one cycle after any unmasked source is pending, provided that one of these holds: nothing is in service; the scan reaches an unmasked pending source before any in-service one; or the first in-service source the scan reaches is a cascade source that is unmasked and pending again.
- R5: In auto-rotate mode, the interrupt output is high one cycle after an unmasked source is pending while the in-service register is zero, and low otherwise.
- R6: An acknowledge (rdStrobe=1, rdStatus=0, rdNoSide=0) chooses the first unmasked pending source in the scan. It sets that source's in-service bit and pulses its bit on pendClr in the same cycle. The interrupt output is low in the next cycle. In auto-rotate mode, the pointer moves to the chosen source.
- R7: A return (rdStatus=1, rdNoSide=0) chooses the first in-service source in the scan and clears its in-service bit. In auto-rotate mode, the pointer rotates up by one position whether or not a source was found.
- R8: rdVector is {4'hF, n} when the chosen source n is a cascade source, and {base, n} otherwise. It is {base, 4'hF} when no source qualifies or the pointer is zero.
- R9: In fixed mode, a cascade source counts its nested acknowledges. Each return decrements the count, and the in-service bit clears only on the return that brings the count to zero.
- R10: Writing a 0 to a cascade-select bit resets that source's nesting count. A single later return then clears its in-service bit.
- R11: An acknowledge with no qualifying source pulses pendClr[15] when topLineEdge is 1. In auto-rotate mode, that acknowledge also clears the pointer to zero.
- R12: A read with rdNoSide=1 returns the same vector but leaves the in-service register and the pointer unchanged, and pulses no pendClr bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendIn | input | 16 | Pending requests from the capture logic |
| topLineEdge | input | 1 | Source 15 is edge-captured; enables the R11 clear |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select (encoding in R3) |
| regWrData | input | 16 | Register write data |
| rdStrobe | input | 1 | Acknowledge/return read strobe |
| rdStatus | input | 1 | 0 = acknowledge, 1 = return |
| rdNoSide | input | 1 | Read without state change |
| rdVector | output | 8 | Vector for the current read (combinational) |
| pendClr | output | 16 | One-hot clear pulse to the capture logic |
| intOut | output | 1 | Registered interrupt request |
| inSvcOut | output | 16 | In-service register |
| firstPriOut | output | 16 | One-hot first-priority pointer |

## Verification
A wrong in-service bit or a wrong pointer value shows on inSvcOut or firstPriOut at the clock edge after the cycle that caused it. It also shows in the vector of the next acknowledge or return. A wrong nesting count is hidden until the return that should, or should not, empty that source; the in-service bit then shows the error on that edge. The interrupt output is checked one cycle after every change of state or pending input, so a wrong arbitration decision shows within one cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // register select codes
  typedef enum logic [2:0] {
    SEL_MASK  = 3'd0,
    SEL_INSVC = 3'd1,
    SEL_CASC  = 3'd2,
    SEL_FIRST = 3'd3,
    SEL_BASE  = 3'd4,
    SEL_MODE  = 3'd5
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ack;
    logic ret;
    logic wrMask;
    logic wrInSvc;
    logic wrCasc;
    logic wrFirst;
    logic wrBase;
    logic wrMode;
  } arbCmd_t;

  // arbitration status from datapath to control
  typedef struct packed {
    logic unmAny;       // some unmasked source pending
    logic svcAny;       // something in service
    logic hitFresh;     // scan meets an unmasked pending source first
    logic hitCascAgain; // scan meets an in-service cascade source that is pending again
  } arbStat_t;

endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  first,
  output logic [N-1:0]  hitOh,
  output logic [IW-1:0] hitIdx,
  output logic          hitAny
);

  logic [IW-1:0] startIdx;
  logic          startAny;

  // locate the pointer bit
  always_comb begin
    startIdx = '0;
    startAny = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (first[i]) begin
        startIdx = IW'(i);
        startAny = 1'b1;
      end
    end
  end

  // circular upward search from the pointer
  always_comb begin
    hitOh  = '0;
    hitIdx = '0;
    hitAny = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (startAny && !hitAny && req[(int'(startIdx) + k) % N]) begin
        hitAny = 1'b1;
        hitIdx = IW'((int'(startIdx) + k) % N);
        hitOh[(int'(startIdx) + k) % N] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IW    = $clog2(N),
  parameter int unsigned VW    = 2 * IW
) (
  input  logic          clk,
  input  logic          rstN,
  input  arbCmd_t       cmd,
  input  logic [N-1:0]  wrData,
  input  logic [N-1:0]  pendIn,
  input  logic          topLineEdge,
  input  logic          rdStatus,
  output arbStat_t      stat,
  output logic          fixedMode,
  output logic [VW-1:0] rdVector,
  output logic [N-1:0]  pendClr,
  output logic [N-1:0]  inSvcOut,
  output logic [N-1:0]  firstPriOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [N-1:0]     TOP_BIT = N'(1) << (N - 1);

  logic [N-1:0]     maskQ, inSvcQ, cascQ, firstQ;
  logic [IW-1:0]    baseQ;
  logic             fixedQ;
  logic [CNT_W-1:0] cntQ [N];
  logic [N-1:0]     lastNest;

  logic [N-1:0]  unmPend;
  logic [N-1:0]  ackOh, retOh, intOh;
  logic [IW-1:0] ackIdx, retIdx, intIdx;
  logic          ackAny, retAny, intAny;

  assign unmPend = pendIn & ~maskQ;

  irq_prio_scan #(.N(N), .IW(IW)) ackScan_i (
    .req(unmPend), .first(firstQ), .hitOh(ackOh), .hitIdx(ackIdx), .hitAny(ackAny));

  irq_prio_scan #(.N(N), .IW(IW)) retScan_i (
    .req(inSvcQ), .first(firstQ), .hitOh(retOh), .hitIdx(retIdx), .hitAny(retAny));

  irq_prio_scan #(.N(N), .IW(IW)) intScan_i (
    .req(unmPend | inSvcQ), .first(firstQ), .hitOh(intOh), .hitIdx(intIdx), .hitAny(intAny));

  // status for the request decision
  always_comb begin
    stat.unmAny       = |unmPend;
    stat.svcAny       = |inSvcQ;
    stat.hitFresh     = intAny && |(intOh & ~inSvcQ);
    stat.hitCascAgain = intAny && |(intOh & inSvcQ & cascQ & unmPend);
  end

  // vector for the selected read kind
  logic [N-1:0]  selOh;
  logic [IW-1:0] selIdx;
  logic          selAny;

  always_comb begin
    selOh  = rdStatus ? retOh  : ackOh;
    selIdx = rdStatus ? retIdx : ackIdx;
    selAny = rdStatus ? retAny : ackAny;
    if (!selAny)
      rdVector = {baseQ, {IW{1'b1}}};
    else if (|(selOh & cascQ))
      rdVector = {{IW{1'b1}}, selIdx};
    else
      rdVector = {baseQ, selIdx};
  end

  // clear pulse toward the capture logic
  always_comb begin
    pendClr = '0;
    if (cmd.ack) begin
      if (ackAny)
        pendClr = ackOh;
      else if (topLineEdge)
        pendClr = TOP_BIT;
    end
  end

  // in-service bits that a return really drops
  logic [N-1:0] retDrop;
  assign retDrop = retOh & ~(fixedQ ? (cascQ & ~lastNest) : '0);

  // next state
  logic [N-1:0] inSvcNext, firstNext;

  always_comb begin
    inSvcNext = inSvcQ;
    if (cmd.ack && ackAny) inSvcNext = inSvcNext | ackOh;
    if (cmd.ret && retAny) inSvcNext = inSvcNext & ~retDrop;
    if (cmd.wrInSvc)       inSvcNext = wrData;
  end

  always_comb begin
    firstNext = firstQ;
    if (!fixedQ) begin
      if (cmd.ack)
        firstNext = ackAny ? ackOh : '0;
      else if (cmd.ret)
        firstNext = {firstQ[N-2:0], firstQ[N-1]};
    end
    if (cmd.wrFirst)
      firstNext = N'(1) << wrData[IW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '1;
      inSvcQ <= '0;
      cascQ  <= '0;
      firstQ <= N'(1);
      baseQ  <= '0;
      fixedQ <= 1'b0;
    end else begin
      inSvcQ <= inSvcNext;
      firstQ <= firstNext;
      if (cmd.wrMask) maskQ  <= wrData;
      if (cmd.wrCasc) cascQ  <= wrData;
      if (cmd.wrBase) baseQ  <= wrData[2*IW-1:IW];
      if (cmd.wrMode) fixedQ <= wrData[0];
    end
  end

  // per-source nesting counts for cascade sources
  for (genvar g = 0; g < N; g++) begin : gNest
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cntQ[g] <= '0;
      else if (cmd.wrCasc && !wrData[g])
        cntQ[g] <= '0;
      else if (fixedQ && cascQ[g]) begin
        if (cmd.ack && ackOh[g] && cntQ[g] != CNT_MAX)
          cntQ[g] <= cntQ[g] + 1'b1;
        else if (cmd.ret && retOh[g] && cntQ[g] != '0)
          cntQ[g] <= cntQ[g] - 1'b1;
      end
    end
    assign lastNest[g] = (cntQ[g] <= CNT_W'(1));
  end

  assign fixedMode   = fixedQ;
  assign inSvcOut    = inSvcQ;
  assign firstPriOut = firstQ;

endmodule

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regSel,
  input  logic       rdStrobe,
  input  logic       rdStatus,
  input  logic       rdNoSide,
  input  arbStat_t   stat,
  input  logic       fixedMode,
  output arbCmd_t    cmd,
  output logic       intOut
);

  regSel_e selCode;
  assign selCode = regSel_e'(regSel);

  always_comb begin
    cmd     = '0;
    cmd.ack = rdStrobe && !rdStatus && !rdNoSide;
    cmd.ret = rdStrobe &&  rdStatus && !rdNoSide;
    if (regWrEn) begin
      case (selCode)
        SEL_MASK:  cmd.wrMask  = 1'b1;
        SEL_INSVC: cmd.wrInSvc = 1'b1;
        SEL_CASC:  cmd.wrCasc  = 1'b1;
        SEL_FIRST: cmd.wrFirst = 1'b1;
        SEL_BASE:  cmd.wrBase  = 1'b1;
        SEL_MODE:  cmd.wrMode  = 1'b1;
        default:   ;
      endcase
    end
  end

  logic intReq;

  always_comb begin
    if (fixedMode)
      intReq = stat.unmAny && (!stat.svcAny || stat.hitFresh || stat.hitCascAgain);
    else
      intReq = stat.unmAny && !stat.svcAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      intOut <= 1'b0;
    else
      intOut <= cmd.ack ? 1'b0 : intReq;
  end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned NEST_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned VEC_W  = 2 * IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendIn,
  input  logic               topLineEdge,
  input  logic               regWrEn,
  input  logic [2:0]         regSel,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic               rdStrobe,
  input  logic               rdStatus,
  input  logic               rdNoSide,
  output logic [VEC_W-1:0]   rdVector,
  output logic [NUM_SRC-1:0] pendClr,
  output logic               intOut,
  output logic [NUM_SRC-1:0] inSvcOut,
  output logic [NUM_SRC-1:0] firstPriOut
);

  arbCmd_t  cmd;
  arbStat_t stat;
  logic     fixedMode;

  irq_arb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .rdStrobe(rdStrobe), .rdStatus(rdStatus), .rdNoSide(rdNoSide),
    .stat(stat), .fixedMode(fixedMode), .cmd(cmd), .intOut(intOut));

  irq_arb_datapath #(.N(NUM_SRC), .CNT_W(NEST_W), .IW(IDX_W), .VW(VEC_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(regWrData), .pendIn(pendIn),
    .topLineEdge(topLineEdge), .rdStatus(rdStatus), .stat(stat),
    .fixedMode(fixedMode), .rdVector(rdVector), .pendClr(pendClr),
    .inSvcOut(inSvcOut), .firstPriOut(firstPriOut));

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         regWrEn,
  input logic         rdStrobe,
  input logic         rdStatus,
  input logic         rdNoSide,
  input logic [N-1:0] pendClr,
  input logic [N-1:0] inSvcOut,
  input logic [N-1:0] firstPriOut
);

  a_r3_first_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(firstPriOut));

  a_r6_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendClr));

  a_r6_clear_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr != '0) |-> (rdStrobe && !rdStatus && !rdNoSide));

  a_r7_return_no_grow: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdStatus && !rdNoSide && !regWrEn)
      |=> ($countones(inSvcOut) <= $countones($past(inSvcOut))));

  a_r12_no_side_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdNoSide && !regWrEn)
      |=> ($stable(inSvcOut) && $stable(firstPriOut)));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.N(NUM_SRC)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .rdStrobe(rdStrobe),
  .rdStatus(rdStatus), .rdNoSide(rdNoSide), .pendClr(pendClr),
  .inSvcOut(inSvcOut), .firstPriOut(firstPriOut));

// File: tb/irq_prio_arbiter_tb_top.sv
module irq_prio_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pendIn = '0;
  logic        topLineEdge = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [15:0] regWrData = '0;
  logic        rdStrobe = 1'b0;
  logic        rdStatus = 1'b0;
  logic        rdNoSide = 1'b0;
  logic [7:0]  rdVector;
  logic [15:0] pendClr;
  logic        intOut;
  logic [15:0] inSvcOut;
  logic [15:0] firstPriOut;

  always #10 clk = ~clk;

  irq_prio_arbiter dut_i (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .topLineEdge(topLineEdge),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .rdStrobe(rdStrobe), .rdStatus(rdStatus), .rdNoSide(rdNoSide),
    .rdVector(rdVector), .pendClr(pendClr), .intOut(intOut),
    .inSvcOut(inSvcOut), .firstPriOut(firstPriOut));

  int nChecks = 0;
  int nErrors = 0;

  // reference state built from the requirements
  logic [15:0] mMask, mInSvc, mCasc, mFirst;
  logic [3:0]  mBase;
  logic        mFixed;
  int          mCnt [16];

  localparam int KIDLE = 0, KWR = 1, KRD = 2;

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int scanIdx(logic [15:0] req, logic [15:0] fst);
    int s = -1;
    for (int i = 0; i < 16; i++) if (fst[i] && s < 0) s = i;
    if (s < 0) return -1;
    for (int k = 0; k < 16; k++) if (req[(s + k) % 16]) return (s + k) % 16;
    return -1;
  endfunction

  function automatic logic intReqModel(logic [15:0] pend);
    logic [15:0] unm = pend & ~mMask;
    int h;
    if (unm == 0) return 1'b0;
    if (!mFixed) return (mInSvc == 0);
    if (mInSvc == 0) return 1'b1;
    h = scanIdx(unm | mInSvc, mFirst);
    if (h < 0) return 1'b0;
    if (!mInSvc[h]) return 1'b1;
    return mCasc[h] && unm[h];
  endfunction

  function automatic logic [7:0] vecModel(int h);
    if (h < 0) return {mBase, 4'hF};
    if (mCasc[h]) return {4'hF, 4'(h)};
    return {mBase, 4'(h)};
  endfunction

  task automatic step(input int kind, input logic [2:0] sel, input logic [15:0] data,
                      input logic st, input logic ns, input logic [15:0] pend,
                      input logic e15, input string tag);
    logic [15:0] unm, expClr;
    logic        expInt, sideAck;
    int          ackH, retH;
    @(negedge clk);
    regWrEn = (kind == KWR); regSel = sel; regWrData = data;
    rdStrobe = (kind == KRD); rdStatus = st; rdNoSide = ns;
    pendIn = pend; topLineEdge = e15;
    #5;
    unm  = pend & ~mMask;
    ackH = scanIdx(unm, mFirst);
    retH = scanIdx(mInSvc, mFirst);
    sideAck = (kind == KRD) && !st && !ns;
    expClr = '0;
    if (sideAck) expClr = (ackH >= 0) ? (16'd1 << ackH) : (e15 ? 16'h8000 : 16'h0);
    if (kind == KRD) check(rdVector, vecModel(st ? retH : ackH), tag, "R8 vector");
    check(pendClr, expClr, tag, "R6 pendClr");
    expInt = sideAck ? 1'b0 : intReqModel(pend);
    @(posedge clk);
    // update reference
    if (kind == KWR) begin
      case (sel)
        3'd0: mMask = data;
        3'd1: mInSvc = data;
        3'd2: begin
          mCasc = data;
          for (int i = 0; i < 16; i++) if (!data[i]) mCnt[i] = 0;
        end
        3'd3: mFirst = 16'd1 << data[3:0];
        3'd4: mBase = data[7:4];
        3'd5: mFixed = data[0];
        default: ;
      endcase
    end else if (kind == KRD && !ns) begin
      if (!st) begin
        if (ackH >= 0) begin
          if (mFixed && mCasc[ackH] && mCnt[ackH] < 15) mCnt[ackH]++;
          mInSvc[ackH] = 1'b1;
          if (!mFixed) mFirst = 16'd1 << ackH;
        end else if (!mFixed) mFirst = '0;
      end else begin
        if (retH >= 0) begin
          if (mFixed && mCasc[retH]) begin
            if (mCnt[retH] <= 1) mInSvc[retH] = 1'b0;
            if (mCnt[retH] > 0) mCnt[retH]--;
          end else mInSvc[retH] = 1'b0;
        end
        if (!mFixed) mFirst = {mFirst[14:0], mFirst[15]};
      end
    end
    #1;
    check(intOut, expInt, tag, "intOut");
    check(inSvcOut, mInSvc, tag, "inSvc");
    check(firstPriOut, mFirst, tag, "firstPri");
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data, input string tag);
    step(KWR, sel, data, 1'b0, 1'b0, 16'h0, 1'b0, tag);
  endtask

  logic [31:0] lf = 32'h1234_5678;
  function automatic logic [31:0] nextLf(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    #(20 * 200000);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    mMask = '1; mInSvc = '0; mCasc = '0; mFirst = 16'h0001; mBase = '0; mFixed = 1'b0;
    for (int i = 0; i < 16; i++) mCnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    check(intOut, 1'b0, "R1", "intOut");
    check(inSvcOut, 16'h0, "R1", "inSvc");
    check(firstPriOut, 16'h0001, "R1", "firstPri");
    check(pendClr, 16'h0, "R1", "pendClr");
    // R2 all sources masked by reset value
    step(KIDLE, 3'd0, 16'h0, 1'b0, 1'b0, 16'hFFFF, 1'b0, "R2");
    step(KIDLE, 3'd0, 16'h0, 1'b0, 1'b0, 16'hFFFF, 1'b0, "R2");
    wr(3'd0, 16'hFFFB, "R2");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0006, 1'b0, "R2");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R7");
    wr(3'd0, 16'h0000, "R2");
    // R3 every pointer position, with R6 and R7 in auto mode
    for (int f = 0; f < 16; f++) begin
      wr(3'd3, 16'(f), "R3");
      step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'hFFFF, 1'b0, "R3");
      step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R7");
    end
    wr(3'd6, 16'hFFFF, "R3");
    wr(3'd7, 16'hFFFF, "R3");
    // R5 auto mode request
    wr(3'd3, 16'd0, "R3");
    step(KIDLE, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0010, 1'b0, "R5");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0010, 1'b0, "R6");
    step(KIDLE, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0010, 1'b0, "R5");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R7");
    // R8 vector base
    wr(3'd4, 16'h00A0, "R8");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0100, 1'b0, "R8");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R8");
    // R4 fixed mode nesting
    wr(3'd5, 16'h0001, "R4");
    wr(3'd3, 16'd0, "R4");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0020, 1'b0, "R4");
    step(KIDLE, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0008, 1'b0, "R4");
    step(KIDLE, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0200, 1'b0, "R4");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R4");
    // R9 cascade nesting
    wr(3'd2, 16'h0004, "R9");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0004, 1'b0, "R9");
    step(KIDLE, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0004, 1'b0, "R9");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0004, 1'b0, "R9");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R9");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R9");
    // R10 count reset by cascade-select write
    wr(3'd2, 16'h0008, "R10");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0008, 1'b0, "R10");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0008, 1'b0, "R10");
    wr(3'd2, 16'h0000, "R10");
    wr(3'd2, 16'h0008, "R10");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R10");
    // R11 empty acknowledge
    wr(3'd5, 16'h0000, "R11");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0000, 1'b1, "R11");
    wr(3'd3, 16'd2, "R11");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0000, 1'b0, "R11");
    wr(3'd3, 16'd2, "R11");
    // R12 reads without side effects
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b1, 16'h0040, 1'b1, "R12");
    step(KRD, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0040, 1'b0, "R12");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b1, 16'h0000, 1'b0, "R12");
    step(KRD, 3'd0, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, "R12");
    // long mixed sweep in both modes
    for (int n = 0; n < 6000; n++) begin
      int op;
      logic [31:0] a;
      lf = nextLf(lf); a = lf; lf = nextLf(lf);
      op = int'(a[3:0]);
      if (op <= 2)
        wr(a[6:4], (a[2:0] == 3'd0) ? (lf[31:16] & lf[15:0]) : lf[31:16], mFixed ? "R4" : "R5");
      else if (op <= 14)
        step(KRD, 3'd0, 16'h0, op >= 10 && op <= 13, op == 14, lf[31:16] & lf[15:0] & a[31:16],
             a[8], mFixed ? "R4" : "R5");
      else
        step(KIDLE, 3'd0, 16'h0, 1'b0, 1'b0, lf[31:16] & lf[15:0], 1'b0, mFixed ? "R4" : "R5");
    end
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule